// File: doc/BRIEF.md
# Warp Memory Request Queue Selector

This block sits between the warp scheduler and the memory coalescing stage. Memory instructions issued by warps are held in a bank of small FIFO queues, one queue per group of warps. Each cycle the block offers one queued instruction downstream. Instructions can therefore leave in a different order than they were issued, and one warp can be favoured over another without involving the scheduler.

Two ordering policies are available. In age mode the queue head that was issued earliest wins. In warp-priority mode the queue head with the numerically smallest warp number wins. The policy is chosen by a small cache-sensitivity monitor. It watches L1 access and miss pulses over fixed windows of accesses. At each window boundary it enables warp-priority mode for the following window if that window's misses exceeded a programmable threshold.

Both data interfaces use valid/ready. An instruction transfers on any rising clock edge where valid and ready are both high. `in_ready` depends only on the queue that `in_warp` selects, so a full queue stalls only the warps that map to it. Once `out_valid` is high and `out_ready` is low, the offered instruction is held unchanged until it is taken.

Top module: `wrq_selector`

## Requirements
- R1: After reset, `out_valid` is 0, `in_ready` is 1 for every warp, and `mode_warp` is 0 (age mode).
- R2: Warp w is stored in queue (w mod NUM_Q), and each queue holds Q_DEPTH entries. While a queue is full, `in_ready` is 0 for every warp that maps to it and stays 1 for warps that map to other queues.
- R3: Instructions from the same queue leave in the order they were accepted.
- R4: In age mode (`mode_warp`=0), the offered instruction is the one accepted earliest among all queue heads.
- R5: In warp-priority mode (`mode_warp`=1), the offered instruction is the queue head with the smallest warp number.
- R6: While `out_valid`=1 and `out_ready`=0, `out_valid`, `out_warp` and `out_tag` stay unchanged on the next cycle. This holds even if a higher-priority instruction arrives in the meantime.
- R7: After every WIN_LEN accepted access pulses (`acc_valid`=1), `mode_warp` becomes 1 if the number of those pulses that had `acc_miss`=1 is strictly greater than `miss_thresh`, and 0 otherwise. `acc_miss` is ignored on cycles where `acc_valid` is 0.
- R8: `mode_warp` changes only on the clock edge that completes a window.
- R9: An issue attempt made while `in_ready` is 0 is dropped. It never appears at the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Issue request valid |
| in_ready | output | 1 | Queue of `in_warp` can accept |
| in_warp | input | 6 | Issuing warp number |
| in_tag | input | 23 | Instruction metadata tag |
| out_valid | output | 1 | An instruction is offered |
| out_ready | input | 1 | Coalescing stage accepts |
| out_warp | output | 6 | Warp of offered instruction |
| out_tag | output | 23 | Tag of offered instruction |
| acc_valid | input | 1 | One L1 access this cycle |
| acc_miss | input | 1 | That access missed |
| miss_thresh | input | 11 | Miss count threshold per window |
| mode_warp | output | 1 | 1 = warp-priority mode, 0 = age mode |

## Verification
Some properties are checked by assertions on every cycle. No queue is pushed while full or popped while empty. A stalled offer holds its warp and tag. The chosen queue always has a valid head. The policy flag moves only on a window-completing edge. The ordering rules can only be shown by scenarios whose expected sequence is worked out in the bench. These are age order, warp-number order among heads, FIFO order inside a queue, and the exact miss-versus-threshold decision including the equal case. The same holds for dropped issues to a full queue.

// File: rtl/wrq_pkg.sv
package wrq_pkg;
  localparam int WARP_W = 6;
  localparam int TAG_W  = 23;
  localparam int SEQ_W  = 8;

  // One queued instruction: 6 + 23 + 8 = 37 bits
  typedef struct packed {
    logic [WARP_W-1:0] warp;
    logic [TAG_W-1:0]  tag;
    logic [SEQ_W-1:0]  seq;
  } wrq_entry_t;
endpackage

// File: rtl/wrq_fifo.sv
module wrq_fifo
  import wrq_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int PW = $clog2(DEPTH)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       push,
  input  wrq_entry_t din,
  input  logic       pop,
  output wrq_entry_t head,
  output logic       nonempty,
  output logic       full
);
  wrq_entry_t    mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [PW:0]   count;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) begin
        mem[wr_ptr] <= din;
        wr_ptr      <= wr_ptr + 1'b1;
      end
      if (pop) rd_ptr <= rd_ptr + 1'b1;
      if (push && !pop)      count <= count + 1'b1;
      else if (pop && !push) count <= count - 1'b1;
    end
  end

  assign head     = mem[rd_ptr];
  assign nonempty = (count != '0);
  assign full     = (count == (PW+1)'(DEPTH));

  // R2
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);
  // R9
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> nonempty);
endmodule

// File: rtl/wrq_pick.sv
module wrq_pick
  import wrq_pkg::*;
#(
  parameter int NUM_Q = 16,
  localparam int QW = $clog2(NUM_Q)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NUM_Q-1:0] head_v,
  input  wrq_entry_t       heads [NUM_Q],
  input  logic [SEQ_W-1:0] cur_seq,
  input  logic             mode_warp,
  output logic             any,
  output logic [QW-1:0]    idx
);
  logic [SEQ_W-1:0]  best_age, age_i;
  logic [WARP_W-1:0] best_w;
  logic              take;

  always_comb begin
    any      = 1'b0;
    idx      = '0;
    best_age = '0;
    best_w   = '0;
    age_i    = '0;
    take     = 1'b0;
    for (int i = 0; i < NUM_Q; i++) begin
      age_i = cur_seq - heads[i].seq;
      take  = 1'b0;
      if (head_v[i]) begin
        if (!any)           take = 1'b1;
        else if (mode_warp) take = (heads[i].warp < best_w);
        else                take = (age_i > best_age);
      end
      if (take) begin
        any      = 1'b1;
        idx      = QW'(i);
        best_age = age_i;
        best_w   = heads[i].warp;
      end
    end
  end

  // R4
  grant_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    any |-> head_v[idx]);
endmodule

// File: rtl/wrq_mode.sv
module wrq_mode #(
  parameter int WIN_LEN = 1024,
  localparam int CW  = $clog2(WIN_LEN),
  localparam int MCW = $clog2(WIN_LEN + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           acc_valid,
  input  logic           acc_miss,
  input  logic [MCW-1:0] thresh,
  output logic           mode_warp
);
  logic [CW-1:0]  win_cnt;
  logic [MCW-1:0] miss_cnt;
  logic [MCW:0]   total;
  logic           win_end;

  assign win_end = acc_valid && (win_cnt == CW'(WIN_LEN - 1));
  assign total   = {1'b0, miss_cnt} + (MCW+1)'(acc_valid && acc_miss);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      win_cnt   <= '0;
      miss_cnt  <= '0;
      mode_warp <= 1'b0;
    end else if (win_end) begin
      win_cnt   <= '0;
      miss_cnt  <= '0;
      mode_warp <= (total > {1'b0, thresh});
    end else if (acc_valid) begin
      win_cnt  <= win_cnt + 1'b1;
      miss_cnt <= total[MCW-1:0];
    end
  end

  // R8
  mode_at_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mode_warp) |-> $past(win_end));
endmodule

// File: rtl/wrq_selector.sv
module wrq_selector
  import wrq_pkg::*;
#(
  parameter int NUM_Q   = 16,
  parameter int Q_DEPTH = 8,
  parameter int WIN_LEN = 1024,
  localparam int QW    = $clog2(NUM_Q),
  localparam int THR_W = $clog2(WIN_LEN + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WARP_W-1:0] in_warp,
  input  logic [TAG_W-1:0]  in_tag,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WARP_W-1:0] out_warp,
  output logic [TAG_W-1:0]  out_tag,
  input  logic              acc_valid,
  input  logic              acc_miss,
  input  logic [THR_W-1:0]  miss_thresh,
  output logic              mode_warp
);
  logic [NUM_Q-1:0] q_push, q_pop, q_nonempty, q_full;
  wrq_entry_t       q_head [NUM_Q];
  wrq_entry_t       new_entry;
  logic [QW-1:0]    in_q, pick_q, sel_q, hold_q;
  logic             pick_any, hold_v;
  logic [SEQ_W-1:0] seq_cnt;

  assign in_q      = in_warp[QW-1:0];
  assign in_ready  = !q_full[in_q];
  assign new_entry = '{warp: in_warp, tag: in_tag, seq: seq_cnt};

  genvar g;
  generate
    for (g = 0; g < NUM_Q; g++) begin : g_queue
      assign q_push[g] = in_valid && in_ready && (in_q == QW'(g));
      assign q_pop[g]  = out_valid && out_ready && (sel_q == QW'(g));
      wrq_fifo #(.DEPTH(Q_DEPTH)) u_fifo (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (q_push[g]),
        .din      (new_entry),
        .pop      (q_pop[g]),
        .head     (q_head[g]),
        .nonempty (q_nonempty[g]),
        .full     (q_full[g])
      );
    end
  endgenerate

  wrq_pick #(.NUM_Q(NUM_Q)) u_pick (
    .clk       (clk),
    .rst_n     (rst_n),
    .head_v    (q_nonempty),
    .heads     (q_head),
    .cur_seq   (seq_cnt),
    .mode_warp (mode_warp),
    .any       (pick_any),
    .idx       (pick_q)
  );

  wrq_mode #(.WIN_LEN(WIN_LEN)) u_mode (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_valid (acc_valid),
    .acc_miss  (acc_miss),
    .thresh    (miss_thresh),
    .mode_warp (mode_warp)
  );

  // A stalled offer locks its queue so the payload stays put.
  assign sel_q     = hold_v ? hold_q : pick_q;
  assign out_valid = pick_any;
  assign out_warp  = q_head[sel_q].warp;
  assign out_tag   = q_head[sel_q].tag;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_v  <= 1'b0;
      hold_q  <= '0;
      seq_cnt <= '0;
    end else begin
      hold_v <= out_valid && !out_ready;
      hold_q <= sel_q;
      if (in_valid && in_ready) seq_cnt <= seq_cnt + 1'b1;
    end
  end

  // R6
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_warp) && $stable(out_tag));
endmodule

// File: tb/tb_wrq_selector.sv
module tb_wrq_selector;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid, in_ready, out_valid, out_ready;
  logic [5:0]  in_warp, out_warp;
  logic [22:0] in_tag, out_tag;
  logic        acc_valid, acc_miss, mode_warp;
  logic [10:0] miss_thresh;

  always #5 clk = ~clk;

  wrq_selector dut (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_warp(in_warp), .in_tag(in_tag),
    .out_valid(out_valid), .out_ready(out_ready), .out_warp(out_warp), .out_tag(out_tag),
    .acc_valid(acc_valid), .acc_miss(acc_miss), .miss_thresh(miss_thresh),
    .mode_warp(mode_warp)
  );

  int    checks = 0;
  int    fails  = 0;
  bit    done   = 0;
  string cur_req = "R4";
  logic [5:0]  exp_w [$];
  logic [22:0] exp_t [$];

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Monitor: compares every transfer against the scoreboard.
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n === 1'b1 && out_valid && out_ready) begin
        if (exp_w.size() == 0) begin
          check(0, "R9", "unexpected output warp", int'(out_warp), -1);
        end else begin
          logic [5:0]  w;
          logic [22:0] t;
          w = exp_w.pop_front();
          t = exp_t.pop_front();
          check(out_warp == w, cur_req, "out_warp", int'(out_warp), int'(w));
          check(out_tag == t, cur_req, "out_tag", int'(out_tag), int'(t));
        end
      end
    end
  end

  task automatic push(input int w, input int t, input bit rec);
    in_warp  = 6'(w);
    in_tag   = 23'(t);
    in_valid = 1'b1;
    do @(negedge clk); while (!in_ready);
    if (rec) begin
      exp_w.push_back(6'(w));
      exp_t.push_back(23'(t));
    end
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  task automatic expect_item(input int w, input int t);
    exp_w.push_back(6'(w));
    exp_t.push_back(23'(t));
  endtask

  task automatic drain(input string req);
    out_ready = 1'b1;
    for (int i = 0; i < 60; i++) begin
      if (exp_w.size() == 0) break;
      @(posedge clk); #1;
    end
    @(negedge clk);
    check(exp_w.size() == 0, req, "items left in scoreboard", exp_w.size(), 0);
    check(out_valid == 1'b0, req, "out_valid after drain", int'(out_valid), 0);
    @(posedge clk); #1;
  endtask

  // Drive one full window of accesses; check the mode just before and after its end.
  task automatic window(input int nmiss, input bit mode_before, input bit mode_after);
    for (int i = 0; i < 1024; i++) begin
      acc_valid = 1'b1;
      acc_miss  = (i < nmiss);
      if (i == 1023) begin
        @(negedge clk);
        check(mode_warp == mode_before, "R8", "mode before window end",
              int'(mode_warp), int'(mode_before));
      end
      @(posedge clk); #1;
    end
    acc_valid = 1'b0;
    acc_miss  = 1'b0;
    @(negedge clk);
    check(mode_warp == mode_after, "R7", "mode after window", int'(mode_warp), int'(mode_after));
    @(posedge clk); #1;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_warp = '0; in_tag = '0;
    out_ready = 1'b0; acc_valid = 1'b0; acc_miss = 1'b0; miss_thresh = 11'd100;
    repeat (3) @(posedge clk);
    #1;
    @(negedge clk);
    check(out_valid == 1'b0, "R1", "out_valid in reset", int'(out_valid), 0);
    check(in_ready == 1'b1, "R1", "in_ready in reset", int'(in_ready), 1);
    check(mode_warp == 1'b0, "R1", "mode in reset", int'(mode_warp), 0);
    @(posedge clk); #1;
    rst_n = 1'b1;
    @(posedge clk); #1;

    // R4: stalled fill in age mode leaves in issue order
    cur_req = "R4";
    push(33, 1, 1); push(5, 2, 1); push(16, 3, 1); push(2, 4, 1); push(0, 5, 1);
    @(negedge clk);
    check(out_valid == 1'b1, "R4", "out_valid after fill", int'(out_valid), 1);
    @(posedge clk); #1;
    drain("R4");

    // R4: streaming with the consumer always ready
    out_ready = 1'b1;
    for (int i = 0; i < 10; i++) push((i * 7) % 48, 50 + i, 1);
    drain("R4");

    // R2, R3, R9: fill queue 3 completely
    cur_req = "R3";
    out_ready = 1'b0;
    for (int i = 0; i < 8; i++) push(3, 100 + i, 1);
    in_warp = 6'd3;
    @(negedge clk);
    check(in_ready == 1'b0, "R2", "in_ready warp 3 full", int'(in_ready), 0);
    @(posedge clk); #1;
    in_warp = 6'd19;
    @(negedge clk);
    check(in_ready == 1'b0, "R2", "in_ready warp 19 shares queue", int'(in_ready), 0);
    @(posedge clk); #1;
    in_warp = 6'd4;
    @(negedge clk);
    check(in_ready == 1'b1, "R2", "in_ready warp 4 other queue", int'(in_ready), 1);
    @(posedge clk); #1;
    in_valid = 1'b1; in_warp = 6'd19; in_tag = 23'd999;
    repeat (3) @(posedge clk);
    #1;
    in_valid = 1'b0;
    push(4, 200, 1);
    drain("R9");

    // R7, R8: mode windows
    window(101, 1'b0, 1'b1);
    acc_valid = 1'b0; acc_miss = 1'b1;
    repeat (5) @(posedge clk);
    #1;
    acc_miss = 1'b0;
    window(100, 1'b1, 1'b0);
    window(1024, 1'b0, 1'b1);

    // R5: warp-priority order among heads; first offer is locked while stalled
    cur_req = "R5";
    out_ready = 1'b0;
    push(33, 11, 0); push(5, 12, 0); push(16, 13, 0); push(2, 14, 0); push(0, 15, 0);
    expect_item(33, 11); expect_item(2, 14); expect_item(5, 12);
    expect_item(16, 13); expect_item(0, 15);
    drain("R5");

    // R6: a lower warp arriving during a stall does not displace the offer
    cur_req = "R6";
    out_ready = 1'b0;
    push(9, 21, 1);
    push(1, 22, 1);
    repeat (3) @(posedge clk);
    #1;
    @(negedge clk);
    check(out_warp == 6'd9, "R6", "held warp during stall", int'(out_warp), 9);
    check(out_tag == 23'd21, "R6", "held tag during stall", int'(out_tag), 21);
    @(posedge clk); #1;
    drain("R6");

    window(0, 1'b1, 1'b0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule